// File: doc/BRIEF.md
# RTC Alarm and Interrupt Flag Unit

This block is the alarm and interrupt-status part of a PC-style real-time clock. The time-of-day counter lives elsewhere and hands over its current seconds, minutes, hours, day-of-month and month values. It also supplies a one-second tick, an update-ended pulse and a qualified 32.768 kHz reference tick. On every one-second tick the block compares the current time against programmable alarm fields. An alarm field holding 0xFF matches any value.

Three event sources set flags: a periodic divider running from the reference, the alarm compare and the update-ended pulse. The flags are sticky and latch whether or not their source is enabled. One interrupt output, mirrored by a summary flag, rises only when a latched flag meets its enable. Software reaches everything through a byte-wide register port with a 3-bit address. Reading the flag register both returns it and clears it.

Register map (address: content): 0 seconds alarm, 1 minutes alarm, 2 hours alarm, 3 day-of-month alarm, 4 month alarm, 5 periodic rate code (low nibble), 6 control, 7 flags (read-only). Writes are accepted when `wr_en` is high at a clock edge. `rdata` is combinational from `addr`.

Top module: `rtc_alarm_irq_unit`

## Requirements
- R1: After reset the control register reads 0x02, the rate register reads 0x06, the flag register reads 0x00 and `irq` is low.
- R2: The alarm flag (flag bit 5) is set at the clock edge of a cycle with `sec_tick` high in which every enabled alarm field matches its current-time input. Without `sec_tick`, matching fields set nothing.
- R3: An alarm field holding 0xFF matches any current value of its time field.
- R4: A non-wildcard alarm field must be valid to match. In BCD mode (control bit 2 = 0) this means both nibbles are at most 9, seconds and minutes are below 0x60, hours below 0x24, day below 0x32 and month below 0x13. In binary mode (control bit 2 = 1) the limits are 60, 60, 24, 32 and 13. An invalid field never matches, even when it equals the time input.
- R5: With day and month alarms built in, the day-of-month alarm compares and reads back only its low 6 bits (0xFF stays a wildcard). The month alarm compares all 8 bits. A mismatch in either blocks the alarm.
- R6: With rate code n in 1..15, the periodic flag (flag bit 6) sets on every 2^(n-1)-th reference tick, counted from reset or from the last write to the rate register. Code 0 stops periodic events. The reset code 6 gives one event per 32 reference ticks (1024 Hz).
- R7: An `upd_done` pulse sets the update flag (flag bit 4).
- R8: Flags latch regardless of their enables. Control bits 6, 5 and 4 enable periodic, alarm and update respectively. Flag bit 7 and `irq` are high only while some flag is set together with its enable.
- R9: A read of address 7 returns the flags present before that edge and clears them at that edge, so `irq` is low from the next cycle. An event arriving in the same cycle as the read is kept.
- R10: The control register keeps only bits 6, 5, 4 and 2. Bit 1 (24-hour mode) always reads 1 and the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears flags when addr is 7) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr |
| sec_tick | input | 1 | One-cycle pulse once per second |
| upd_done | input | 1 | One-cycle pulse when a time update has finished |
| ref_tick | input | 1 | One-cycle pulse per reference-clock period |
| cur_sec | input | 8 | Current seconds |
| cur_min | input | 8 | Current minutes |
| cur_hour | input | 8 | Current hours (24-hour) |
| cur_mday | input | 8 | Current day of month |
| cur_mon | input | 8 | Current month |
| irq | output | 1 | Interrupt, high while an enabled flag is set |

## Verification
The bench builds the block with both the day-of-month and the month alarm present. This makes the full one-year alarm reachable, including the 6-bit day masking and a month mismatch that blocks an otherwise matching alarm. The prescaler keeps its default 15-bit width. The bench drives the reference tick directly, so rate codes 1, 3 and the reset code 6 can be checked at their exact tick counts.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] A_SEC   = 3'd0;
  localparam logic [REG_AW-1:0] A_MIN   = 3'd1;
  localparam logic [REG_AW-1:0] A_HOUR  = 3'd2;
  localparam logic [REG_AW-1:0] A_MDAY  = 3'd3;
  localparam logic [REG_AW-1:0] A_MON   = 3'd4;
  localparam logic [REG_AW-1:0] A_RATE  = 3'd5;
  localparam logic [REG_AW-1:0] A_CTRL  = 3'd6;
  localparam logic [REG_AW-1:0] A_FLAGS = 3'd7;

  // control bit positions; flag bits share 6..4 with the enables
  localparam int B_SUM = 7;
  localparam int B_PER = 6;
  localparam int B_ALM = 5;
  localparam int B_UPD = 4;
  localparam int B_BIN = 2;
  localparam int B_H24 = 1;

  localparam logic [7:0] CTRL_KEEP  = 8'h74;
  localparam logic [7:0] CTRL_FIXED = 8'h02;
  localparam logic [7:0] WILD       = 8'hFF;
  localparam logic [3:0] RATE_RST   = 4'd6;

  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } rtc_evt_t;

  function automatic logic field_ok(logic [7:0] v, logic [7:0] bcd_lim,
                                    logic [7:0] bin_lim, logic bin_mode);
    if (bin_mode) return v < bin_lim;
    return (v < bcd_lim) && (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9);
  endfunction

  function automatic logic field_hit(logic [7:0] alm, logic [7:0] cur,
                                     logic [7:0] bcd_lim, logic [7:0] bin_lim,
                                     logic bin_mode);
    if (alm == WILD) return 1'b1;
    return field_ok(alm, bcd_lim, bin_lim, bin_mode) && (alm == cur);
  endfunction

  // low-bit mask whose all-ones pattern marks the last tick of a period
  function automatic logic [15:0] rate_mask(logic [3:0] r);
    if (r == 4'd0) return 16'd0;
    return (16'd1 << (r - 4'd1)) - 16'd1;
  endfunction

endpackage

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
#(
  parameter bit HAS_MDAY = 1'b1,
  parameter bit HAS_MON  = 1'b1
) (
  input  logic [7:0] alm_sec,
  input  logic [7:0] alm_min,
  input  logic [7:0] alm_hour,
  input  logic [7:0] alm_mday,
  input  logic [7:0] alm_mon,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] cur_mday,
  input  logic [7:0] cur_mon,
  input  logic       bin_mode,
  input  logic       sec_tick,
  output logic       alarm_hit
);

  logic sec_ok, min_ok, hour_ok, mday_ok, mon_ok;

  assign sec_ok  = field_hit(alm_sec,  cur_sec,  8'h60, 8'd60, bin_mode);
  assign min_ok  = field_hit(alm_min,  cur_min,  8'h60, 8'd60, bin_mode);
  assign hour_ok = field_hit(alm_hour, cur_hour, 8'h24, 8'd24, bin_mode);

  generate
    if (HAS_MDAY) begin : g_mday
      logic [7:0] mday_cmp;
      assign mday_cmp = (alm_mday == WILD) ? WILD : (alm_mday & 8'h3F);
      assign mday_ok  = field_hit(mday_cmp, cur_mday, 8'h32, 8'd32, bin_mode);
    end else begin : g_no_mday
      assign mday_ok = 1'b1;
    end
    if (HAS_MDAY && HAS_MON) begin : g_mon
      assign mon_ok = field_hit(alm_mon, cur_mon, 8'h13, 8'd13, bin_mode);
    end else begin : g_no_mon
      assign mon_ok = 1'b1;
    end
  endgenerate

  assign alarm_hit = sec_tick && sec_ok && min_ok && hour_ok && mday_ok && mon_ok;

endmodule

// File: rtl/rtc_periodic_gen.sv
module rtc_periodic_gen
  import rtc_alarm_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       restart,
  input  logic [3:0] rate,
  output logic       per_evt
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  assign mask    = rate_mask(rate)[CNT_W-1:0];
  assign per_evt = ref_tick && (rate != 4'd0) && ((cnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (ref_tick) cnt_q <= cnt_q + 1'b1;
  end

  p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));

endmodule

// File: rtl/rtc_event_flags.sv
module rtc_event_flags
  import rtc_alarm_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  rtc_evt_t evt,
  input  rtc_evt_t en,
  input  logic     clr,
  output rtc_evt_t flag_q,
  output logic     summary
);

  rtc_evt_t flag_d;

  always_comb begin
    if (clr) flag_d = evt;
    else     flag_d = flag_q | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign summary = |(flag_q & en);

  p_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt.alm |=> flag_q.alm);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (evt == '0)) |=> (flag_q == '0));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

endmodule

// File: rtl/rtc_alarm_irq_unit.sv
module rtc_alarm_irq_unit
  import rtc_alarm_pkg::*;
#(
  parameter bit HAS_MDAY = 1'b1,
  parameter bit HAS_MON  = 1'b1,
  parameter int PRESC_W  = 15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic        sec_tick,
  input  logic        upd_done,
  input  logic        ref_tick,
  input  logic [7:0]  cur_sec,
  input  logic [7:0]  cur_min,
  input  logic [7:0]  cur_hour,
  input  logic [7:0]  cur_mday,
  input  logic [7:0]  cur_mon,
  output logic        irq
);

  logic [7:0] alm_sec_q, alm_min_q, alm_hour_q, alm_mday_q, alm_mon_q;
  logic [7:0] ctrl_q;
  logic [3:0] rate_q;
  logic       alarm_hit, per_evt, flag_clr, rate_wr, summary;
  rtc_evt_t   evt, en, flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_sec_q  <= '0;
      alm_min_q  <= '0;
      alm_hour_q <= '0;
      alm_mday_q <= '0;
      alm_mon_q  <= '0;
      rate_q     <= RATE_RST;
      ctrl_q     <= CTRL_FIXED;
    end else if (wr_en) begin
      case (addr)
        A_SEC:   alm_sec_q  <= wdata;
        A_MIN:   alm_min_q  <= wdata;
        A_HOUR:  alm_hour_q <= wdata;
        A_MDAY:  alm_mday_q <= wdata;
        A_MON:   alm_mon_q  <= wdata;
        A_RATE:  rate_q     <= wdata[3:0];
        A_CTRL:  ctrl_q     <= (wdata & CTRL_KEEP) | CTRL_FIXED;
        default: ;
      endcase
    end
  end

  assign rate_wr  = wr_en && (addr == A_RATE);
  assign flag_clr = rd_en && (addr == A_FLAGS);

  rtc_alarm_match #(.HAS_MDAY(HAS_MDAY), .HAS_MON(HAS_MON)) u_match (
    .alm_sec(alm_sec_q), .alm_min(alm_min_q), .alm_hour(alm_hour_q),
    .alm_mday(alm_mday_q), .alm_mon(alm_mon_q),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_mday(cur_mday), .cur_mon(cur_mon),
    .bin_mode(ctrl_q[B_BIN]), .sec_tick(sec_tick), .alarm_hit(alarm_hit)
  );

  rtc_periodic_gen #(.CNT_W(PRESC_W)) u_periodic (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .restart(rate_wr),
    .rate(rate_q), .per_evt(per_evt)
  );

  assign evt = '{per: per_evt, alm: alarm_hit, upd: upd_done};
  assign en  = '{per: ctrl_q[B_PER], alm: ctrl_q[B_ALM], upd: ctrl_q[B_UPD]};

  rtc_event_flags u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .en(en), .clr(flag_clr),
    .flag_q(flag_q), .summary(summary)
  );

  assign irq = summary;

  always_comb begin
    case (addr)
      A_SEC:   rdata = alm_sec_q;
      A_MIN:   rdata = alm_min_q;
      A_HOUR:  rdata = alm_hour_q;
      A_MDAY:  rdata = HAS_MDAY ? (alm_mday_q & 8'h3F) : 8'h00;
      A_MON:   rdata = (HAS_MDAY && HAS_MON) ? alm_mon_q : 8'h00;
      A_RATE:  rdata = {4'h0, rate_q};
      A_CTRL:  rdata = ctrl_q;
      default: rdata = {summary, flag_q, 4'h0};
    endcase
  end

  p_tick_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> !$rose(flag_q.alm));

  p_rate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == 4'd0) |=> !$rose(flag_q.per));

  p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[B_PER:B_UPD] == 3'b000) |-> !irq);

  p_h24_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_CTRL) |=> (ctrl_q[B_H24] && ctrl_q[7] == 1'b0));

endmodule

// File: tb/rtc_alarm_irq_unit_bench.sv
module rtc_alarm_irq_unit_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sec_tick = 1'b0, upd_done = 1'b0, ref_tick = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_mday = '0, cur_mon = '0;
  logic       irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #4 clk = ~clk;

  rtc_alarm_irq_unit #(.HAS_MDAY(1'b1), .HAS_MON(1'b1)) u_rtc_alarm_irq_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sec_tick(sec_tick), .upd_done(upd_done),
    .ref_tick(ref_tick), .cur_sec(cur_sec), .cur_min(cur_min),
    .cur_hour(cur_hour), .cur_mday(cur_mday), .cur_mon(cur_mon), .irq(irq)
  );

  task automatic report(string tag, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  // monitor: compares each read against the scoreboard
  always @(negedge clk) begin
    if (rd_en) begin
      if (exp_q.size() == 0) begin
        report("scoreboard underflow", rdata, 8'hxx);
      end else begin
        report(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    step();
    rd_en = 1'b0;
  endtask

  task automatic pulse_sec();
    sec_tick = 1'b1; step(); sec_tick = 1'b0;
  endtask

  task automatic pulse_upd();
    upd_done = 1'b1; step(); upd_done = 1'b0;
  endtask

  task automatic ref_ticks(int n);
    for (int i = 0; i < n; i++) begin
      ref_tick = 1'b1; step();
    end
    ref_tick = 1'b0;
  endtask

  task automatic chk_irq(logic exp, string tag);
    report(tag, {7'd0, irq}, {7'd0, exp});
  endtask

  task automatic finish_run();
    if (exp_q.size() != 0) report("scoreboard leftover", 8'(exp_q.size()), 8'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    rd(3'd6, 8'h02, "R1 ctrl reset");
    rd(3'd5, 8'h06, "R1 rate reset");
    rd(3'd7, 8'h00, "R1 flags reset");
    chk_irq(1'b0, "R1 irq reset");

    // R6 reset rate 6: 32 reference ticks per event
    ref_ticks(31);
    rd(3'd7, 8'h00, "R6 no event before 32nd tick");
    ref_ticks(1);
    rd(3'd7, 8'h40, "R6 event on 32nd tick at rate 6");
    wr(3'd5, 8'h00);

    // R2 full alarm in BCD mode
    cur_sec = 8'h30; cur_min = 8'h15; cur_hour = 8'h10; cur_mday = 8'h05; cur_mon = 8'h03;
    wr(3'd0, 8'h30); wr(3'd1, 8'h15); wr(3'd2, 8'h10); wr(3'd3, 8'h05); wr(3'd4, 8'h03);
    wr(3'd6, 8'h20);
    step();
    rd(3'd7, 8'h00, "R2 no alarm without tick");
    pulse_sec();
    chk_irq(1'b1, "R2 irq on alarm match");
    rd(3'd7, 8'hA0, "R2 alarm flag and summary");
    chk_irq(1'b0, "R9 irq low after flag read");
    rd(3'd7, 8'h00, "R9 flags cleared by read");

    // R3 wildcard
    cur_sec = 8'h42;
    wr(3'd0, 8'hFF);
    pulse_sec();
    rd(3'd7, 8'hA0, "R3 wildcard seconds");
    wr(3'd1, 8'h16);
    pulse_sec();
    rd(3'd7, 8'h00, "R2 minute mismatch blocks alarm");
    wr(3'd1, 8'h15);

    // R5 day and month
    wr(3'd3, 8'h06);
    pulse_sec();
    rd(3'd7, 8'h00, "R5 day mismatch blocks alarm");
    wr(3'd3, 8'hC5);
    rd(3'd3, 8'h05, "R5 day readback low 6 bits");
    pulse_sec();
    rd(3'd7, 8'hA0, "R5 day compares low 6 bits");
    wr(3'd4, 8'h04);
    pulse_sec();
    rd(3'd7, 8'h00, "R5 month mismatch blocks alarm");
    wr(3'd4, 8'hFF);
    pulse_sec();
    rd(3'd7, 8'hA0, "R3 wildcard month");

    // R4 validity per data mode
    cur_sec = 8'h3B;
    wr(3'd0, 8'h3B);
    pulse_sec();
    rd(3'd7, 8'h00, "R4 invalid BCD seconds never match");
    wr(3'd6, 8'h24);
    pulse_sec();
    rd(3'd7, 8'hA0, "R4 binary 59 seconds matches");
    wr(3'd6, 8'h20);

    // R10 control bit storage
    wr(3'd6, 8'hFF);
    rd(3'd6, 8'h76, "R10 ctrl keeps 6,5,4,2 and bit1");
    wr(3'd6, 8'h00);
    rd(3'd6, 8'h02, "R10 24-hour bit reads 1");

    // R7 / R8 masked latching
    pulse_upd();
    chk_irq(1'b0, "R8 disabled flag raises no irq");
    rd(3'd7, 8'h10, "R7 update flag latched while disabled");
    wr(3'd6, 8'h10);
    pulse_upd();
    chk_irq(1'b1, "R8 enabled update raises irq");
    rd(3'd7, 8'h90, "R8 summary with update flag");

    // R9 event in the same cycle as the read
    upd_done = 1'b1;
    rd(3'd7, 8'h00, "R9 read returns pre-edge flags");
    upd_done = 1'b0;
    chk_irq(1'b1, "R9 same-cycle event kept");
    rd(3'd7, 8'h90, "R9 same-cycle event readable");

    // R6 other rates
    wr(3'd6, 8'h00);
    wr(3'd5, 8'h01);
    ref_ticks(1);
    rd(3'd7, 8'h40, "R6 rate 1 every tick");
    wr(3'd5, 8'h00);
    ref_ticks(5);
    rd(3'd7, 8'h00, "R6 rate 0 stops events");
    wr(3'd5, 8'h03);
    ref_ticks(3);
    rd(3'd7, 8'h00, "R6 rate 3 not before 4th tick");
    ref_ticks(1);
    rd(3'd7, 8'h40, "R6 rate 3 on 4th tick");
    wr(3'd6, 8'h40);
    ref_ticks(4);
    chk_irq(1'b1, "R8 periodic irq when enabled");
    rd(3'd7, 8'hC0, "R6 periodic flag with summary");

    done = 1'b1;
    step();
    finish_run();
  end

endmodule